// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is a bank of 256 byte-wide configuration registers that a host reaches through two adjacent I/O addresses on a byte-wide bus. The even address is the selector: writing it stores an 8-bit pointer. The odd address is the window: writing it stores a byte into the register that the pointer names, and reading it returns that register through a readability filter.

Only a fixed set of pointer values can be read back. Two identification slots return their stored value with some bits cleared. Every other window read, and every read of the selector address, returns all ones. The full contents of the register bank are driven on a wide output so that downstream decode logic can use them directly.

The bus uses single-cycle strobes, so there is no valid/ready pair. Each read strobe that hits the port produces one cycle of `cfg_rvalid` with registered data. There is no back-pressure: the host must take the data on that cycle.

Top module: `cfg_index_port`

## Requirements
- R1: After reset (active-low `rst_n`), the pointer and all 256 registers are zero, `cfg_rvalid` is low and `cfg_rdata` is 0x00.
- R2: A write strobe at address 0x0022 (bit 0 clear, upper bits matching) stores all 8 bits of `cfg_wdata` as the pointer.
- R3: A write strobe at address 0x0023 stores `cfg_wdata` into the register the pointer selects, for every pointer value 0x00 to 0xFF. Register n occupies bits [8n+7:8n] of `reg_image`.
- R4: A read strobe at address 0x0022 returns 0xFF.
- R5: A window read with pointer 0x04 returns the stored byte ANDed with 0x1C, which clears bits 7, 6, 5, 1 and 0.
- R6: A window read with pointer 0x08 returns the stored byte ANDed with 0x1F, which clears bits 7 to 5.
- R7: A window read with pointer 0x05, 0x06, 0x09 to 0x13, or 0x28 to 0x2A returns the stored byte unchanged.
- R8: A window read with any pointer not named in R5 to R7 returns 0xFF.
- R9: Strobes at any address other than 0x0022 or 0x0023 change neither the pointer nor any register, and produce no `cfg_rvalid`.
- R10: Read data appears on `cfg_rdata` with `cfg_rvalid` high exactly one clock after a decoded read strobe. In every other cycle `cfg_rvalid` is low and `cfg_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 16 | I/O address |
| cfg_rd | input | 1 | Read strobe, one cycle |
| cfg_wr | input | 1 | Write strobe, one cycle |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Registered read data, zero when not valid |
| cfg_rvalid | output | 1 | Read data valid, one cycle after a decoded read |
| reg_image | output | 2048 | Raw contents of all 256 registers, register n at bits [8n+7:8n] |

## Verification
The assertions check the following on every cycle: the pointer update, the landing of a window write in the selected register, a stable bank when no window write occurs, the one-cycle latency of `cfg_rvalid`, zero data outside valid cycles, the all-ones selector read, and the identification mask at pointer 0x04. Only the bench's scenarios can confirm the full readability list and the 0xFF return for unlisted pointers, including the list edges at 0x13/0x14 and 0x27/0x28. The same holds for the top slot 0xFF, the immunity of state to neighbouring addresses, and the clearing effect of a second reset.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int DW    = 8;
  localparam int IDX_W = 8;
  localparam int NREG  = 1 << IDX_W;

  localparam logic [DW-1:0] ID_A_IDX  = 8'h04;
  localparam logic [DW-1:0] ID_A_KEEP = 8'h1C;
  localparam logic [DW-1:0] ID_B_IDX  = 8'h08;
  localparam logic [DW-1:0] ID_B_KEEP = 8'h1F;
  localparam logic [DW-1:0] ALL_ONES  = '1;

  // Readability filter for a window read.
  function automatic logic [DW-1:0] window_view(input logic [IDX_W-1:0] idx,
                                                input logic [DW-1:0] val);
    logic [DW-1:0] r;
    if (idx == ID_A_IDX)                              r = val & ID_A_KEEP;
    else if (idx == ID_B_IDX)                         r = val & ID_B_KEEP;
    else if (idx == 8'h05 || idx == 8'h06)            r = val;
    else if (idx >= 8'h09 && idx <= 8'h13)            r = val;
    else if (idx >= 8'h28 && idx <= 8'h2A)            r = val;
    else                                              r = ALL_ONES;
    return r;
  endfunction
endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'h0022
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic              sel_wr,
  output logic              win_wr,
  output logic              sel_rd,
  output logic              win_rd
);
  localparam logic [ADDR_W-1:0] BASE_W = ADDR_W'(BASE_ADDR);

  logic hit;
  assign hit    = (addr[ADDR_W-1:1] == BASE_W[ADDR_W-1:1]);
  assign sel_wr = hit && wr && !addr[0];
  assign win_wr = hit && wr &&  addr[0];
  assign sel_rd = hit && rd && !addr[0];
  assign win_rd = hit && rd &&  addr[0];
endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile
  import cfgp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel_wr,
  input  logic                 win_wr,
  input  logic [DW-1:0]        wdata,
  output logic [IDX_W-1:0]     idx_q,
  output logic [DW-1:0]        cur_val,
  output logic [NREG*DW-1:0]   image
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (sel_wr) idx_q <= wdata;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[g] <= '0;
      else if (win_wr && idx_q == IDX_W'(g)) mem[g] <= wdata;
    end
    assign image[g*DW +: DW] = mem[g];
  end

  assign cur_val = mem[idx_q];

  // R2
  sel_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> idx_q == $past(wdata));

  // R3
  win_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_wr |=> mem[$past(idx_q)] == $past(wdata));

  // R9
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_wr |=> $stable(image));
endmodule

// File: rtl/cfgp_readout.sv
module cfgp_readout
  import cfgp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_rd,
  input  logic             win_rd,
  input  logic [IDX_W-1:0] idx_q,
  input  logic [DW-1:0]    cur_val,
  output logic [DW-1:0]    rdata,
  output logic             rvalid
);
  logic [DW-1:0] nxt;

  always_comb begin
    nxt = '0;
    if (sel_rd)      nxt = ALL_ONES;
    else if (win_rd) nxt = window_view(idx_q, cur_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rdata  <= nxt;
      rvalid <= sel_rd || win_rd;
    end
  end

  // R10
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rd || win_rd) |=> rvalid);

  // R10
  rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> rdata == '0);

  // R4
  sel_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rd |=> rdata == ALL_ONES);

  // R5
  id_a_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_rd && idx_q == ID_A_IDX) |=> (rdata & ~ID_A_KEEP) == '0);
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfgp_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_ADDR = 16'h0022
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic                 cfg_rd,
  input  logic                 cfg_wr,
  input  logic [DW-1:0]        cfg_wdata,
  output logic [DW-1:0]        cfg_rdata,
  output logic                 cfg_rvalid,
  output logic [NREG*DW-1:0]   reg_image
);
  logic sel_wr, win_wr, sel_rd, win_rd;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    cur_val;

  cfgp_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr(cfg_addr), .rd(cfg_rd), .wr(cfg_wr),
    .sel_wr(sel_wr), .win_wr(win_wr), .sel_rd(sel_rd), .win_rd(win_rd)
  );

  cfgp_regfile u_rf (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .win_wr(win_wr),
    .wdata(cfg_wdata), .idx_q(idx_q), .cur_val(cur_val), .image(reg_image)
  );

  cfgp_readout u_ro (
    .clk(clk), .rst_n(rst_n), .sel_rd(sel_rd), .win_rd(win_rd),
    .idx_q(idx_q), .cur_val(cur_val), .rdata(cfg_rdata), .rvalid(cfg_rvalid)
  );

  // R9
  stray_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr[ADDR_W-1:1] != BASE_ADDR[ADDR_W-1:1]) |=> !cfg_rvalid);
endmodule

// File: tb/test_cfg_index_port.sv
module test_cfg_index_port;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   cfg_addr = '0;
  logic          cfg_rd = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [7:0]    cfg_wdata = '0;
  logic [7:0]    cfg_rdata;
  logic          cfg_rvalid;
  logic [2047:0] reg_image;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  cfg_index_port i_cfg_index_port (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rd(cfg_rd),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_rvalid(cfg_rvalid), .reg_image(reg_image)
  );

  // {op(1=read), addr low byte, data, expected}
  localparam int NV = 31;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'h22, 8'h04, 8'h00}, {1'b0, 8'h23, 8'hFF, 8'h00}, {1'b1, 8'h23, 8'h00, 8'h1C}, // R5
    {1'b0, 8'h22, 8'h08, 8'h00}, {1'b0, 8'h23, 8'hFF, 8'h00}, {1'b1, 8'h23, 8'h00, 8'h1F}, // R6
    {1'b0, 8'h22, 8'h05, 8'h00}, {1'b0, 8'h23, 8'hA5, 8'h00}, {1'b1, 8'h23, 8'h00, 8'hA5}, // R7
    {1'b0, 8'h22, 8'h13, 8'h00}, {1'b0, 8'h23, 8'h3C, 8'h00}, {1'b1, 8'h23, 8'h00, 8'h3C}, // R7
    {1'b0, 8'h22, 8'h2A, 8'h00}, {1'b0, 8'h23, 8'hC3, 8'h00}, {1'b1, 8'h23, 8'h00, 8'hC3}, // R7
    {1'b0, 8'h22, 8'h14, 8'h00}, {1'b0, 8'h23, 8'h55, 8'h00}, {1'b1, 8'h23, 8'h00, 8'hFF}, // R8
    {1'b1, 8'h22, 8'h00, 8'hFF},                                                           // R4
    {1'b0, 8'h22, 8'h09, 8'h00}, {1'b0, 8'h23, 8'h81, 8'h00}, {1'b1, 8'h23, 8'h00, 8'h81}, // R7
    {1'b0, 8'h22, 8'h27, 8'h00}, {1'b0, 8'h23, 8'h11, 8'h00}, {1'b1, 8'h23, 8'h00, 8'hFF}, // R8
    {1'b0, 8'h22, 8'h28, 8'h00}, {1'b0, 8'h23, 8'h7E, 8'h00}, {1'b1, 8'h23, 8'h00, 8'h7E}, // R7
    {1'b0, 8'h22, 8'h06, 8'h00}, {1'b0, 8'h23, 8'h0F, 8'h00}, {1'b1, 8'h23, 8'h00, 8'h0F}  // R7
  };

  task automatic check(input string req, input logic [2047:0] act, input logic [2047:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Returns data and valid sampled at the negedge after the capturing edge.
  task automatic io_read(input logic [15:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    cfg_addr = a; cfg_rd = 1'b1;
    @(negedge clk);
    cfg_rd = 1'b0;
    d = cfg_rdata; v = cfg_rvalid;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0]    d;
    logic          v;
    logic [2047:0] snap;
    logic [2047:0] exp_img;

    do_reset();
    @(negedge clk);
    // R1 reset state
    check("R1 rvalid", 2048'(cfg_rvalid), 2048'(0));
    check("R1 rdata", 2048'(cfg_rdata), 2048'(0));
    check("R1 image", reg_image, '0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) begin
        io_read({8'h00, VEC[i][23:16]}, d, v);
        check("R4-R8 vector read", 2048'(d), 2048'(VEC[i][7:0]));
        check("R10 rvalid", 2048'(v), 2048'(1));
      end else begin
        io_write({8'h00, VEC[i][23:16]}, VEC[i][15:8]);
      end
    end

    // R3: raw image holds unmasked bytes; R5 slot stored as 0xFF
    check("R3 image slot 04", 2048'(reg_image[4*8 +: 8]), 2048'(8'hFF));
    check("R3 image slot 14", 2048'(reg_image[20*8 +: 8]), 2048'(8'h55));

    // R3: top slot 0xFF, R2: full 8-bit pointer
    io_write(16'h0022, 8'hFF);
    io_write(16'h0023, 8'h5A);
    check("R3 image slot FF", 2048'(reg_image[2047:2040]), 2048'(8'h5A));
    io_read(16'h0023, d, v);
    check("R8 slot FF read", 2048'(d), 2048'(8'hFF));

    // R10: data back to zero on the following cycle
    @(negedge clk);
    check("R10 idle rvalid", 2048'(cfg_rvalid), 2048'(0));
    check("R10 idle rdata", 2048'(cfg_rdata), 2048'(0));

    // R9: stray addresses
    io_write(16'h0022, 8'h05);
    snap = reg_image;
    io_write(16'h0122, 8'h09);
    io_write(16'h0024, 8'h09);
    io_write(16'h0123, 8'hEE);
    io_write(16'h0021, 8'hEE);
    check("R9 image unchanged", reg_image, snap);
    io_read(16'h0024, d, v);
    check("R9 stray rvalid", 2048'(v), 2048'(0));
    check("R9 stray rdata", 2048'(d), 2048'(0));
    io_read(16'h0023, d, v);
    check("R9 pointer unchanged", 2048'(d), 2048'(8'hA5));

    // R3: window write lands only in the selected slot
    exp_img = snap;
    exp_img[5*8 +: 8] = 8'h66;
    io_write(16'h0023, 8'h66);
    check("R3 single slot write", reg_image, exp_img);

    // R1: second reset clears bank and pointer
    do_reset();
    @(negedge clk);
    check("R1 image after reset", reg_image, '0);
    io_write(16'h0023, 8'h77);
    check("R1 pointer zero", 2048'(reg_image[7:0]), 2048'(8'h77));
    io_write(16'h0022, 8'h05);
    io_read(16'h0023, d, v);
    check("R1 slot 05 cleared", 2048'(d), 2048'(0));

    finish_run();
  end
endmodule